// File: doc/BRIEF.md
# Dual-Bank Endpoint Packet Buffer

This block holds the data path of one USB device endpoint built from two packet banks that alternate between the firmware side and the serial engine side. On an IN endpoint the CPU fills a bank byte by byte and commits it. The serial engine then opens the oldest committed bank, streams it out and frees it. On an OUT endpoint the roles swap: the serial engine fills a free bank and closes it at end of packet, and the CPU drains the oldest bank and releases it. Because there are two banks, one side can work on one bank while the other side works on the second.

A single busy-bank count (0, 1 or 2) drives the ready indications. A kill request lets firmware abort an IN transfer. It retracts the newest committed bank that the host has not started to read. In isochronous use the block reports a host read with nothing to send, and a packet arriving with no free bank. A receive CRC failure is recorded but does not stop the packet from being delivered. Both error flags are sticky and are cleared by a write-one strobe from the CPU. An endpoint reset input frees both banks and clears every flag.

Top module: `ep_dualbank_buf`

## Requirements
- R1: After `rst_n` is released, `busy_banks` is 0, `kill_busy`, `underflow` and `crc_err` are 0, and `tx_ready` equals `dir_in`.
- R2: `busy_banks` rises by one per accepted commit (IN) or end of packet (OUT). It falls by one per finished transmission (`sie_tx_done` while a bank is open), CPU release, or effective kill. It never exceeds 2, and a commit while it is 2 is ignored.
- R3: Banks are served oldest first. `rd_data` shows the byte at the read position of the oldest busy bank, and `rd_len` shows that bank's byte count. The CPU may fill the free bank in the same cycles that the host reads the other one.
- R4: On an IN endpoint, `tx_ready` is 1 whenever fewer than two banks are busy and no kill is in progress. It is therefore high in the cycle right after a commit that leaves the other bank free.
- R5: A `cpu_kill` pulse on an IN endpoint raises `kill_busy` for exactly two cycles. At the second edge, the newest committed bank not being transmitted is freed. If the only busy bank is already being transmitted, nothing changes. Commits are ignored while `kill_busy` is high.
- R6: An `sie_tx_start` on an IN endpoint while no bank is busy sets `underflow` when `iso_mode` is 1, and leaves it unchanged when `iso_mode` is 0.
- R7: An `sie_rx_end` on an OUT endpoint while both banks are busy drops the packet. The count stays 2, the stored banks are unchanged, and `underflow` is set when `iso_mode` is 1.
- R8: An accepted OUT packet closed with `sie_crc_ok` = 0 sets `crc_err`, and it still becomes busy and raises `rx_ready`.
- R9: `underflow` and `crc_err` stay set until cleared. `cpu_flag_clr` bit 0 clears `underflow` and bit 1 clears `crc_err`. A new set event in the same cycle wins over the clear.
- R10: `ep_reset` (synchronous) returns the count to 0, ends any transmission or kill, and clears both error flags.
- R11: On an OUT endpoint, `rx_ready` is 1 exactly when a bank is busy. `rd_avail` is 1 while the oldest bank still has unread bytes, and reads past the end are ignored.
- R12: Writes are ignored while both banks are busy and once the bank holds `BANK_DEPTH` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_reset | input | 1 | Synchronous endpoint reset |
| dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| iso_mode | input | 1 | Isochronous error reporting enable |
| cpu_wr_en | input | 1 | CPU byte write (IN) |
| cpu_wr_data | input | DATA_W | CPU write byte |
| cpu_commit | input | 1 | CPU commits the filled bank (IN) |
| cpu_rd_en | input | 1 | CPU byte read advance (OUT) |
| cpu_release | input | 1 | CPU frees the oldest bank (OUT) |
| cpu_kill | input | 1 | Retract newest unsent bank (IN) |
| cpu_flag_clr | input | 2 | Write-one clear: bit 0 underflow, bit 1 crc_err |
| sie_wr_en | input | 1 | Serial engine byte write (OUT) |
| sie_wr_data | input | DATA_W | Serial engine write byte |
| sie_rx_end | input | 1 | End of received packet (OUT) |
| sie_crc_ok | input | 1 | CRC status with sie_rx_end |
| sie_tx_start | input | 1 | Host IN token: open oldest bank |
| sie_rd_en | input | 1 | Serial engine byte read advance (IN) |
| sie_tx_done | input | 1 | Transmission finished, free bank |
| busy_banks | output | 2 | Number of busy banks |
| tx_ready | output | 1 | A bank is free for the CPU to fill |
| rx_ready | output | 1 | A received bank waits for the CPU |
| rd_avail | output | 1 | Oldest bank has unread bytes |
| rd_data | output | DATA_W | Byte at the read position |
| rd_len | output | $clog2(BANK_DEPTH+1) | Byte count of the oldest bank |
| kill_busy | output | 1 | Kill in progress (self-clearing) |
| underflow | output | 1 | Sticky isochronous underflow/overflow |
| crc_err | output | 1 | Sticky receive CRC error |

## Verification
The IN side is exercised in three ways: filling and sending one bank at a time, filling both banks before any read, and overlapping CPU writes with host reads. Together these separate a correct bank rotation from one that reuses the bank still being read. Kill is tried with one idle bank, one bank under transmission, and two banks with the oldest under transmission, which shows whether the newest or the oldest bank is retracted. The OUT side receives a good packet, a bad-CRC packet and a packet with no room, then drains with an over-read. This checks that the dropped packet leaves the stored data untouched. Every output is compared each cycle with a queue-based model.

// File: rtl/ep_dualbank_pkg.sv
package ep_dualbank_pkg;

  // Next busy-bank count from one increment and two possible decrements.
  function automatic logic [1:0] busy_next(logic [1:0] cur, logic inc,
                                           logic dec_a, logic dec_b);
    return cur + {1'b0, inc} - {1'b0, dec_a} - {1'b0, dec_b};
  endfunction

  // Bank that sits `offs` positions after the oldest busy bank.
  function automatic logic bank_after(logic head, logic [1:0] offs);
    return head ^ offs[0];
  endfunction

  // True when a committed bank exists that the host has not opened.
  function automatic logic has_spare(logic [1:0] busy, logic sending);
    return (busy == 2'd2) || (busy == 2'd1 && !sending);
  endfunction

endpackage

// File: rtl/ep_bank_store.sv
module ep_bank_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              len_we,
  input  logic              len_bank,
  input  logic [PTR_W-1:0]  len_val,
  input  logic              rd_bank,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  rd_len
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);

  logic [DATA_W-1:0] bank_word [2];
  logic [PTR_W-1:0]  bank_len  [2];
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_in_range, rd_in_range;

  assign wr_idx      = wr_ptr[IDX_W-1:0];
  assign rd_idx      = rd_ptr[IDX_W-1:0];
  assign wr_in_range = wr_ptr < CAP;
  assign rd_in_range = rd_ptr < CAP;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] cells [DEPTH];
    logic [PTR_W-1:0]  len_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_in_range && wr_bank == 1'(b))
        cells[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            len_q <= '0;
      else if (clr)                          len_q <= '0;
      else if (len_we && len_bank == 1'(b))  len_q <= len_val;
    end

    assign bank_word[b] = cells[rd_idx];
    assign bank_len[b]  = len_q;
  end

  assign rd_data = rd_in_range ? bank_word[rd_bank] : '0;
  assign rd_len  = bank_len[rd_bank];

  // R3: a stored length never exceeds the bank capacity
  a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_len <= CAP);

endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
  import ep_dualbank_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ep_reset,
  input  logic             dir_in,
  input  logic             cpu_wr_en,
  input  logic             cpu_commit,
  input  logic             cpu_rd_en,
  input  logic             cpu_release,
  input  logic             cpu_kill,
  input  logic             sie_wr_en,
  input  logic             sie_rx_end,
  input  logic             sie_tx_start,
  input  logic             sie_rd_en,
  input  logic             sie_tx_done,
  input  logic [PTR_W-1:0] head_len,
  output logic [1:0]       busy,
  output logic             head,
  output logic             wr_bank,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             wr_fire,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             commit_fire,
  output logic             drop_fire,
  output logic             underrun_fire,
  output logic             kill_busy
);
  localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);

  logic [1:0]       busy_q;
  logic             head_q, tx_act_q, kill_q, kill_done_q;
  logic [PTR_W-1:0] wptr_q, rptr_q;

  logic full, empty, commit_req, wr_req, rd_req;
  logic ev_commit, ev_drop, ev_free, ev_tx_start, ev_underrun;
  logic kill_fire, ev_kill, ev_write, ev_read;

  always_comb begin
    full        = busy_q == 2'd2;
    empty       = busy_q == 2'd0;
    commit_req  = dir_in ? cpu_commit : sie_rx_end;
    wr_req      = dir_in ? cpu_wr_en  : sie_wr_en;
    rd_req      = dir_in ? (sie_rd_en && tx_act_q) : cpu_rd_en;
    ev_commit   = commit_req && !full && !kill_q;
    ev_drop     = !dir_in && sie_rx_end && full;
    ev_free     = dir_in ? (sie_tx_done && tx_act_q) : (cpu_release && !empty);
    ev_tx_start = dir_in && sie_tx_start && !tx_act_q && !empty;
    ev_underrun = dir_in && sie_tx_start && !tx_act_q && empty;
    kill_fire   = kill_q && !kill_done_q;
    ev_kill     = kill_fire && has_spare(busy_q, tx_act_q || ev_tx_start);
    ev_write    = wr_req && !full && (wptr_q < CAP);
    ev_read     = rd_req && !empty && (rptr_q < head_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0; head_q <= 1'b0; tx_act_q <= 1'b0;
      kill_q <= 1'b0; kill_done_q <= 1'b0;
      wptr_q <= '0; rptr_q <= '0;
    end else if (ep_reset) begin
      busy_q <= '0; head_q <= 1'b0; tx_act_q <= 1'b0;
      kill_q <= 1'b0; kill_done_q <= 1'b0;
      wptr_q <= '0; rptr_q <= '0;
    end else begin
      busy_q <= busy_next(busy_q, ev_commit, ev_free, ev_kill);
      if (ev_free) head_q <= ~head_q;

      if (ev_tx_start)  tx_act_q <= 1'b1;
      else if (ev_free) tx_act_q <= 1'b0;

      if (kill_done_q) begin
        kill_q      <= 1'b0;
        kill_done_q <= 1'b0;
      end else if (kill_q) begin
        kill_done_q <= 1'b1;
      end else if (cpu_kill && dir_in) begin
        kill_q <= 1'b1;
      end

      if (ev_commit || ev_kill) wptr_q <= '0;
      else if (ev_write)        wptr_q <= wptr_q + 1'b1;

      if (ev_free)      rptr_q <= '0;
      else if (ev_read) rptr_q <= rptr_q + 1'b1;
    end
  end

  assign busy          = busy_q;
  assign head          = head_q;
  assign wr_bank       = bank_after(head_q, busy_q);
  assign wr_ptr        = wptr_q;
  assign wr_fire       = ev_write;
  assign rd_ptr        = rptr_q;
  assign commit_fire   = ev_commit;
  assign drop_fire     = ev_drop;
  assign underrun_fire = ev_underrun;
  assign kill_busy     = kill_q;

  // R2: the count never reaches the unused code 3
  a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q != 2'd3);

  // R12: with both banks busy the fill position does not move
  a_r12_full_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    full && !ev_kill && !ep_reset |=> $stable(wptr_q));

  // R5: a kill, once raised, stays up through the following edge
  a_r5_kill_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kill_q) |=> kill_q);

  // R5: the kill bit drops after its completion cycle
  a_r5_kill_ends: assert property (@(posedge clk) disable iff (!rst_n)
    kill_done_q |=> !kill_q);

  // R5: no commit raises the count while a kill is pending
  a_r5_commit_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    kill_q && !ep_reset |=> busy_q <= $past(busy_q));

  // R7: a dropped packet leaves both banks busy
  a_r7_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop && !ev_free && !ep_reset |=> busy_q == 2'd2);

endmodule

// File: rtl/ep_flag_unit.sv
module ep_flag_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ep_reset,
  input  logic       iso_mode,
  input  logic       dir_in,
  input  logic       underrun_fire,
  input  logic       drop_fire,
  input  logic       commit_fire,
  input  logic       crc_ok,
  input  logic [1:0] clr,
  output logic       underflow,
  output logic       crc_err
);
  logic uf_q, ce_q, uf_set, ce_set;

  assign uf_set = iso_mode && (underrun_fire || drop_fire);
  assign ce_set = commit_fire && !dir_in && !crc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q <= 1'b0; ce_q <= 1'b0;
    end else if (ep_reset) begin
      uf_q <= 1'b0; ce_q <= 1'b0;
    end else begin
      uf_q <= uf_set || (uf_q && !clr[0]);
      ce_q <= ce_set || (ce_q && !clr[1]);
    end
  end

  assign underflow = uf_q;
  assign crc_err   = ce_q;

  // R9: an uncleared underflow persists
  a_r9_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q && !clr[0] && !ep_reset |=> uf_q);

  // R6: an isochronous empty read is reported
  a_r6_underrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
    iso_mode && underrun_fire && !ep_reset |=> uf_q);

  // R8: a bad-CRC packet is reported
  a_r8_crc_flags: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire && !dir_in && !crc_ok && !ep_reset |=> ce_q);

endmodule

// File: rtl/ep_dualbank_buf.sv
module ep_dualbank_buf #(
  parameter int DATA_W     = 8,
  parameter int BANK_DEPTH = 8,
  localparam int PTR_W     = $clog2(BANK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_reset,
  input  logic              dir_in,
  input  logic              iso_mode,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_commit,
  input  logic              cpu_rd_en,
  input  logic              cpu_release,
  input  logic              cpu_kill,
  input  logic [1:0]        cpu_flag_clr,
  input  logic              sie_wr_en,
  input  logic [DATA_W-1:0] sie_wr_data,
  input  logic              sie_rx_end,
  input  logic              sie_crc_ok,
  input  logic              sie_tx_start,
  input  logic              sie_rd_en,
  input  logic              sie_tx_done,
  output logic [1:0]        busy_banks,
  output logic              tx_ready,
  output logic              rx_ready,
  output logic              rd_avail,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  rd_len,
  output logic              kill_busy,
  output logic              underflow,
  output logic              crc_err
);
  logic [1:0]        busy;
  logic              head, wr_bank, wr_fire;
  logic              commit_fire, drop_fire, underrun_fire, kill_q;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, head_len;
  logic [DATA_W-1:0] wr_data;

  assign wr_data = dir_in ? cpu_wr_data : sie_wr_data;

  ep_bank_ctrl #(.DEPTH(BANK_DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ep_reset      (ep_reset),
    .dir_in        (dir_in),
    .cpu_wr_en     (cpu_wr_en),
    .cpu_commit    (cpu_commit),
    .cpu_rd_en     (cpu_rd_en),
    .cpu_release   (cpu_release),
    .cpu_kill      (cpu_kill),
    .sie_wr_en     (sie_wr_en),
    .sie_rx_end    (sie_rx_end),
    .sie_tx_start  (sie_tx_start),
    .sie_rd_en     (sie_rd_en),
    .sie_tx_done   (sie_tx_done),
    .head_len      (head_len),
    .busy          (busy),
    .head          (head),
    .wr_bank       (wr_bank),
    .wr_ptr        (wr_ptr),
    .wr_fire       (wr_fire),
    .rd_ptr        (rd_ptr),
    .commit_fire   (commit_fire),
    .drop_fire     (drop_fire),
    .underrun_fire (underrun_fire),
    .kill_busy     (kill_q)
  );

  ep_bank_store #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH), .PTR_W(PTR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ep_reset),
    .wr_en    (wr_fire),
    .wr_bank  (wr_bank),
    .wr_ptr   (wr_ptr),
    .wr_data  (wr_data),
    .len_we   (commit_fire),
    .len_bank (wr_bank),
    .len_val  (wr_ptr),
    .rd_bank  (head),
    .rd_ptr   (rd_ptr),
    .rd_data  (rd_data),
    .rd_len   (head_len)
  );

  ep_flag_unit u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .ep_reset      (ep_reset),
    .iso_mode      (iso_mode),
    .dir_in        (dir_in),
    .underrun_fire (underrun_fire),
    .drop_fire     (drop_fire),
    .commit_fire   (commit_fire),
    .crc_ok        (sie_crc_ok),
    .clr           (cpu_flag_clr),
    .underflow     (underflow),
    .crc_err       (crc_err)
  );

  assign busy_banks = busy;
  assign tx_ready   = dir_in && (busy != 2'd2) && !kill_q;
  assign rx_ready   = !dir_in && (busy != 2'd0);
  assign rd_avail   = (busy != 2'd0) && (rd_ptr < head_len);
  assign rd_len     = head_len;
  assign kill_busy  = kill_q;

  // R4: the first commit into an empty IN endpoint leaves it ready again
  a_r4_ready_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    dir_in && busy == 2'd0 && commit_fire && !cpu_kill && !ep_reset |=> tx_ready);

  // R10: endpoint reset empties the banks and flags
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ep_reset |=> busy_banks == 2'd0 && !underflow && !crc_err && !kill_busy);

endmodule

// File: tb/ep_dualbank_buf_tb.sv
`timescale 1ns/1ps
module ep_dualbank_buf_tb;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int PW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ep_reset = 0, dir_in = 1, iso_mode = 1;
  logic cpu_wr_en = 0, cpu_commit = 0, cpu_rd_en = 0, cpu_release = 0, cpu_kill = 0;
  logic [DW-1:0] cpu_wr_data = '0, sie_wr_data = '0;
  logic [1:0] cpu_flag_clr = '0;
  logic sie_wr_en = 0, sie_rx_end = 0, sie_crc_ok = 1, sie_tx_start = 0, sie_rd_en = 0, sie_tx_done = 0;
  logic [1:0] busy_banks;
  logic tx_ready, rx_ready, rd_avail, kill_busy, underflow, crc_err;
  logic [DW-1:0] rd_data;
  logic [PW-1:0] rd_len;

  always #2.5 clk = ~clk;

  ep_dualbank_buf #(.DATA_W(DW), .BANK_DEPTH(DEPTH)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // reference model state
  int q_id[$];
  int q_len[$];
  int wcnt = 0, rcnt = 0, next_id = 1, kstage = 0;
  bit tx_act = 0, m_uf = 0, m_ce = 0;

  function automatic logic [DW-1:0] pat(int id, int i);
    return DW'((id * 29 + i * 7 + 3) & 255);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    q_id.delete(); q_len.delete();
    wcnt = 0; rcnt = 0; tx_act = 0; kstage = 0; m_uf = 0; m_ce = 0;
  endtask

  task automatic model_step();
    int sz, wold;
    bit creq, c_ok, drop, fr, ts, tu, ke, wr, rd;
    sz = q_id.size();
    if (ep_reset) begin model_clear(); return; end
    creq = dir_in ? cpu_commit : sie_rx_end;
    c_ok = creq && sz < 2 && kstage == 0;
    drop = !dir_in && sie_rx_end && sz == 2;
    fr   = dir_in ? (sie_tx_done && tx_act) : (cpu_release && sz > 0);
    ts   = dir_in && sie_tx_start && !tx_act && sz > 0;
    tu   = dir_in && sie_tx_start && !tx_act && sz == 0;
    ke   = kstage == 1 && (sz == 2 || (sz == 1 && !tx_act && !ts));
    wr   = (dir_in ? cpu_wr_en : sie_wr_en) && sz < 2 && wcnt < DEPTH;
    rd   = (dir_in ? (sie_rd_en && tx_act) : cpu_rd_en) && sz > 0 && rcnt < q_len[0];
    m_uf = (iso_mode && (tu || drop)) || (m_uf && !cpu_flag_clr[0]);
    m_ce = (c_ok && !dir_in && !sie_crc_ok) || (m_ce && !cpu_flag_clr[1]);
    if (kstage == 2) kstage = 0;
    else if (kstage == 1) kstage = 2;
    else if (cpu_kill && dir_in) kstage = 1;
    wold = wcnt;
    if (c_ok || ke) wcnt = 0; else if (wr) wcnt++;
    if (fr) rcnt = 0; else if (rd) rcnt++;
    if (ts) tx_act = 1; else if (fr) tx_act = 0;
    if (ke) begin void'(q_id.pop_back()); void'(q_len.pop_back()); end
    if (fr) begin void'(q_id.pop_front()); void'(q_len.pop_front()); end
    if (c_ok) begin q_id.push_back(next_id); q_len.push_back(wold); next_id++; end
  endtask

  task automatic compare();
    int sz;
    bit av;
    sz = q_id.size();
    av = sz > 0 && rcnt < q_len[0];
    check("R2 busy_banks", int'(busy_banks), sz);
    check("R4 tx_ready", int'(tx_ready), int'(dir_in && sz < 2 && kstage == 0));
    check("R11 rx_ready", int'(rx_ready), int'(!dir_in && sz > 0));
    check("R11 rd_avail", int'(rd_avail), int'(av));
    if (av) check("R3 rd_data", int'(rd_data), int'(pat(q_id[0], rcnt)));
    if (sz > 0) check("R3 rd_len", int'(rd_len), q_len[0]);
    check("R5 kill_busy", int'(kill_busy), int'(kstage != 0));
    check("R6 underflow", int'(underflow), int'(m_uf));
    check("R8 crc_err", int'(crc_err), int'(m_ce));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    ep_reset = 0; cpu_wr_en = 0; cpu_commit = 0; cpu_rd_en = 0; cpu_release = 0;
    cpu_kill = 0; cpu_flag_clr = '0; sie_wr_en = 0; sie_rx_end = 0; sie_crc_ok = 1;
    sie_tx_start = 0; sie_rd_en = 0; sie_tx_done = 0;
  endtask

  task automatic cpu_fill(int n);
    for (int i = 0; i < n; i++) begin
      cpu_wr_en = 1; cpu_wr_data = pat(next_id, wcnt); cyc();
    end
  endtask

  task automatic sie_fill(int n);
    for (int i = 0; i < n; i++) begin
      sie_wr_en = 1; sie_wr_data = pat(next_id, wcnt); cyc();
    end
  endtask

  task automatic host_read(int n);
    for (int i = 0; i < n; i++) begin sie_rd_en = 1; cyc(); end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; model_clear();
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy_banks), 0);
    check("R1 tx_ready", int'(tx_ready), 1);
    check("R1 flags", int'({kill_busy, underflow, crc_err}), 0);

    // IN: single bank then second bank
    cpu_fill(4); cpu_commit = 1; cyc();
    check("R4 ready after commit", int'(tx_ready), 1);
    cpu_fill(3); cpu_commit = 1; cyc();
    check("R2 full count", int'(busy_banks), 2);
    check("R4 not ready when full", int'(tx_ready), 0);
    cpu_fill(2); cpu_commit = 1; cyc();
    check("R12 commit while full ignored", int'(busy_banks), 2);
    sie_tx_start = 1; cyc(); host_read(4); sie_tx_done = 1; cyc();
    check("R2 send frees", int'(busy_banks), 1);

    // R3 ping-pong: host reads one bank while CPU fills the other
    sie_tx_start = 1; cyc();
    for (int i = 0; i < 3; i++) begin
      sie_rd_en = 1; cpu_wr_en = 1; cpu_wr_data = pat(next_id, wcnt); cyc();
    end
    sie_tx_done = 1; cyc();
    cpu_commit = 1; cyc();
    check("R3 overlapped bank length", int'(rd_len), 3);

    // R5 kill of one idle bank, with a commit attempt while pending
    cpu_kill = 1; cyc();
    check("R5 kill raised", int'(kill_busy), 1);
    cpu_fill(1); cpu_commit = 1; cyc();
    check("R5 bank retracted", int'(busy_banks), 0);
    cyc();
    check("R5 kill self-clears", int'(kill_busy), 0);

    // R5 kill while the only bank is being sent: no effect
    cpu_fill(2); cpu_commit = 1; cyc();
    sie_tx_start = 1; cyc();
    cpu_kill = 1; cyc(); cyc(); cyc();
    check("R5 kill on sending bank ignored", int'(busy_banks), 1);
    host_read(2); sie_tx_done = 1; cyc();

    // R5 kill with two banks retracts the newest
    cpu_fill(9); cpu_commit = 1; cyc();
    cpu_fill(5); cpu_commit = 1; cyc();
    sie_tx_start = 1; cyc();
    cpu_kill = 1; cyc(); cyc(); cyc();
    check("R5 newest retracted", int'(busy_banks), 1);
    check("R12 capacity limit", int'(rd_len), 8);
    host_read(9);
    check("R11 over-read ignored", int'(rd_avail), 0);
    sie_tx_done = 1; cyc();

    // R6 / R9 isochronous underflow
    sie_tx_start = 1; cyc();
    check("R6 iso empty read", int'(underflow), 1);
    sie_tx_start = 1; cpu_flag_clr = 2'b01; cyc();
    check("R9 set wins over clear", int'(underflow), 1);
    cpu_flag_clr = 2'b01; cyc();
    check("R9 clear", int'(underflow), 0);
    iso_mode = 0; sie_tx_start = 1; cyc();
    check("R6 non-iso no flag", int'(underflow), 0);
    iso_mode = 1;

    // R10 endpoint reset
    sie_tx_start = 1; cyc();
    cpu_fill(2); cpu_commit = 1; cyc();
    ep_reset = 1; cyc();
    check("R10 reset count", int'(busy_banks), 0);
    check("R10 reset flag", int'(underflow), 0);

    // OUT endpoint
    dir_in = 0; ep_reset = 1; cyc();
    check("R11 out idle", int'({tx_ready, rx_ready}), 0);
    sie_fill(5); sie_rx_end = 1; sie_crc_ok = 1; cyc();
    check("R11 rx_ready", int'(rx_ready), 1);
    sie_fill(3); sie_rx_end = 1; sie_crc_ok = 0; cyc();
    check("R8 crc flag", int'(crc_err), 1);
    check("R8 still delivered", int'(busy_banks), 2);
    sie_fill(2); sie_rx_end = 1; cyc();
    check("R7 overflow flag", int'(underflow), 1);
    check("R7 count held", int'(busy_banks), 2);
    check("R7 data kept", int'(rd_len), 5);
    for (int i = 0; i < 6; i++) begin cpu_rd_en = 1; cyc(); end
    check("R11 drained", int'(rd_avail), 0);
    cpu_release = 1; cyc();
    check("R2 release frees", int'(rd_len), 3);
    for (int i = 0; i < 3; i++) begin cpu_rd_en = 1; cyc(); end
    cpu_release = 1; cyc();
    check("R11 empty", int'(rx_ready), 0);
    cpu_flag_clr = 2'b10; cyc();
    check("R9 crc clear", int'(crc_err), 0);
    check("R9 other flag kept", int'(underflow), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule